// File: doc/BRIEF.md
# Programmable LFSR Error Signal Encoder

This block replaces a single pass/fail line from a concurrent error checker with a code word that changes every clock. The sender side holds an L-bit linear feedback shift register whose tap configuration and starting state are loaded at run time. A fixed subset of R register bits, chosen at design time, forms the word that means "no error". A stuck or forced line cannot imitate this word for long, because the expected value keeps moving. When the local checker reports a failure, the sender drives the bitwise complement of that word instead.

The monitor side runs a second register of the same shape. It is loaded and stepped by the same strobes. Each cycle it compares the received word with its own selection of bits. Any difference sets an attack flag, and the flag stays set until reset. Both sides sit in one top module. The received word enters through its own port, so the link between the sides can be modelled or tampered with outside the block.

Top module: `err_sig_encoder`

## Requirements
- R1: Synchronous active-low reset sets both shift registers to the state 16'hACE1, sets both tap configurations to 15'h5008, and clears `attack`.
- R2: One step in Galois form. Stage 0 takes the old stage L-1. Each stage i, from 1 to L-1, takes old stage i-1 XOR (tap bit i-1 AND old stage L-1). Taps bit k therefore gates the feedback into stage k+1.
- R3: A cycle with `cfg_load` high loads `cfg_seed` as the state and `cfg_taps` as the tap configuration into both sides at the next edge. Load takes priority over `step_en`. Later steps use the new taps.
- R4: Loading an all-zero seed gives the state 1 instead, so the register never reaches the all-zero state.
- R5: With `step_en` low and no load, the state holds.
- R6: With `chk_fail` low, `err_word` equals the selected state bits in the same cycle: bit 0 = state[2], bit 1 = state[7], bit 2 = state[13].
- R7: With `chk_fail` high, `err_word` is the bitwise complement of the R6 word.
- R8: If `mon_word_in` differs from the monitor's selected bits (same positions as R6) in a cycle, `attack` is high from the next edge. If the received word always matches, `attack` stays low.
- R9: Once set, `attack` stays high until reset.
- R10: The sender and monitor registers hold equal states at every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load strobe for seed and taps, shared by both sides |
| cfg_seed | input | L | Starting state to load |
| cfg_taps | input | L-1 | Feedback gating, bit k feeds stage k+1 |
| step_en | input | 1 | Advance both registers one step |
| chk_fail | input | 1 | Local checker reports a failure |
| err_word | output | R | Encoded error word from the sender |
| mon_word_in | input | R | Word received by the monitor |
| attack | output | 1 | Sticky attack flag from the monitor |

## Verification
The bench builds the block with its defaults: L = 16, R = 3, selection positions 2, 7 and 13, and a non-zero reset seed. With a 16-bit state, a few hundred steps under several tap settings exercise every feedback gate. Three outputs of three scattered stages make the word depend on both the low and the high end of the register. With R = 3, a one-bit link corruption can be injected. So can a checker failure whose complement is undone by an all-ones corruption, which the monitor must treat as clean.

// File: rtl/errenc_pkg.sv
// Shared constants for the error signal encoder.
// Assumes selection indices are packed IDX_W bits each.
package errenc_pkg;
    localparam int unsigned IDX_W = 8;
endpackage

// File: rtl/errenc_lfsr.sv
// Galois shift register with run-time taps and seed.
// Assumes L >= 2. A zero seed is replaced by 1 on load.
module errenc_lfsr #(
    parameter int unsigned L        = 16,
    parameter logic [L-1:0] RST_SEED = 16'hACE1,
    parameter logic [L-2:0] RST_TAPS = 15'h5008
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [L-1:0] seed,
    input  logic [L-2:0] taps,
    input  logic         step,
    output logic [L-1:0] state
);
    logic [L-1:0] st_q;
    logic [L-2:0] tap_q;
    logic [L-1:0] nxt;

    // Stage 0 always receives the feedback bit.
    assign nxt[0] = st_q[L-1];

    // One gated XOR between each pair of neighbouring stages.
    for (genvar i = 1; i < L; i++) begin : g_stage
        assign nxt[i] = st_q[i-1] ^ (tap_q[i-1] & st_q[L-1]);
    end

    // State and tap storage: reset, load, or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RST_SEED;
            tap_q <= RST_TAPS;
        end else if (load) begin
            st_q  <= (seed == '0) ? {{(L-1){1'b0}}, 1'b1} : seed;
            tap_q <= taps;
        end else if (step) begin
            st_q  <= nxt;
        end
    end

    assign state = st_q;

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> st_q != '0);                                // R4
    AST_ZERO_SEED_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed == '0) |=> st_q == {{(L-1){1'b0}}, 1'b1});      // R4
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(st_q));                          // R5
endmodule

// File: rtl/errenc_sender.sv
// Checker-side encoder: drives the selected LFSR bits, complemented on failure.
// Assumes every SEL_IDX entry is below L.
module errenc_sender
    import errenc_pkg::*;
#(
    parameter int unsigned L          = 16,
    parameter int unsigned R          = 3,
    parameter logic [R*IDX_W-1:0] SEL_IDX = {8'd13, 8'd7, 8'd2},
    parameter logic [L-1:0] RST_SEED  = 16'hACE1,
    parameter logic [L-2:0] RST_TAPS  = 15'h5008
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [L-1:0] seed,
    input  logic [L-2:0] taps,
    input  logic         step,
    input  logic         fail,
    output logic [R-1:0] word,
    output logic [L-1:0] state
);
    logic [R-1:0] sel;

    errenc_lfsr #(.L(L), .RST_SEED(RST_SEED), .RST_TAPS(RST_TAPS)) i_lfsr (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(seed),
        .taps(taps), .step(step), .state(state)
    );

    // Pick the design-time subset of state bits.
    for (genvar k = 0; k < R; k++) begin : g_sel
        localparam int P = int'(SEL_IDX[k*IDX_W +: IDX_W]);
        assign sel[k] = state[P];
    end

    // Complement the whole word when the checker fails.
    assign word = sel ^ {R{fail}};
endmodule

// File: rtl/errenc_monitor.sv
// Monitor side: a twin LFSR predicts the word and latches any mismatch.
// Assumes the same strobes and parameters as the sender.
module errenc_monitor
    import errenc_pkg::*;
#(
    parameter int unsigned L          = 16,
    parameter int unsigned R          = 3,
    parameter logic [R*IDX_W-1:0] SEL_IDX = {8'd13, 8'd7, 8'd2},
    parameter logic [L-1:0] RST_SEED  = 16'hACE1,
    parameter logic [L-2:0] RST_TAPS  = 15'h5008
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [L-1:0] seed,
    input  logic [L-2:0] taps,
    input  logic         step,
    input  logic [R-1:0] rx_word,
    output logic         attack,
    output logic [L-1:0] state
);
    logic [R-1:0] exp_word;
    logic         attack_q;

    errenc_lfsr #(.L(L), .RST_SEED(RST_SEED), .RST_TAPS(RST_TAPS)) i_lfsr (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(seed),
        .taps(taps), .step(step), .state(state)
    );

    // Expected word from the same bit positions as the sender.
    for (genvar k = 0; k < R; k++) begin : g_exp
        localparam int P = int'(SEL_IDX[k*IDX_W +: IDX_W]);
        assign exp_word[k] = state[P];
    end

    // Sticky attack flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  attack_q <= 1'b0;
        else if (rx_word != exp_word) attack_q <= 1'b1;
    end

    assign attack = attack_q;

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        attack_q |=> attack_q);                                       // R9
    AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word != exp_word) |=> attack_q);                          // R8
endmodule

// File: rtl/err_sig_encoder.sv
// Top: the sender encoder and the monitor, sharing load and step strobes.
// Assumes the word link is carried outside via err_word / mon_word_in.
module err_sig_encoder
    import errenc_pkg::*;
#(
    parameter int unsigned L          = 16,
    parameter int unsigned R          = 3,
    parameter logic [R*IDX_W-1:0] SEL_IDX = {8'd13, 8'd7, 8'd2},
    parameter logic [L-1:0] RST_SEED  = 16'hACE1,
    parameter logic [L-2:0] RST_TAPS  = 15'h5008
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_load,
    input  logic [L-1:0] cfg_seed,
    input  logic [L-2:0] cfg_taps,
    input  logic         step_en,
    input  logic         chk_fail,
    output logic [R-1:0] err_word,
    input  logic [R-1:0] mon_word_in,
    output logic         attack
);
    logic [L-1:0] snd_state;
    logic [L-1:0] mon_state;

    errenc_sender #(.L(L), .R(R), .SEL_IDX(SEL_IDX),
                    .RST_SEED(RST_SEED), .RST_TAPS(RST_TAPS)) i_sender (
        .clk(clk), .rst_n(rst_n), .load(cfg_load), .seed(cfg_seed),
        .taps(cfg_taps), .step(step_en), .fail(chk_fail),
        .word(err_word), .state(snd_state)
    );

    errenc_monitor #(.L(L), .R(R), .SEL_IDX(SEL_IDX),
                     .RST_SEED(RST_SEED), .RST_TAPS(RST_TAPS)) i_monitor (
        .clk(clk), .rst_n(rst_n), .load(cfg_load), .seed(cfg_seed),
        .taps(cfg_taps), .step(step_en), .rx_word(mon_word_in),
        .attack(attack), .state(mon_state)
    );

    AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> snd_state == mon_state);                     // R10
endmodule

// File: tb/test_err_sig_encoder.sv
// Bench: behavioural integer model of both sides, compared every cycle.
module test_err_sig_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_seed = '0;
    logic [14:0] cfg_taps = '0;
    logic        step_en = 1'b0;
    logic        chk_fail = 1'b0;
    logic [2:0]  corrupt = '0;
    logic [2:0]  err_word;
    logic [2:0]  mon_word;
    logic        attack;

    int checks = 0;
    int errors = 0;
    int m_state;
    int m_taps;
    bit m_attack;

    always #4 clk = ~clk;   // 125 MHz

    assign mon_word = err_word ^ corrupt;

    err_sig_encoder i_err_sig_encoder (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_seed(cfg_seed),
        .cfg_taps(cfg_taps), .step_en(step_en), .chk_fail(chk_fail),
        .err_word(err_word), .mon_word_in(mon_word), .attack(attack)
    );

    function automatic int model_step(int s, int t);
        int fb = (s >> 15) & 1;
        int n  = (s << 1) & 16'hFFFF;
        if (fb != 0) n = n ^ ((t << 1) | 1);
        return n;
    endfunction

    function automatic int model_sel(int s);
        return ((s >> 2) & 1) | (((s >> 7) & 1) << 1) | (((s >> 13) & 1) << 2);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_load = 1'b0; step_en = 1'b0; chk_fail = 1'b0; corrupt = '0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(attack == 1'b0, "R1 attack in reset", int'(attack), 0);
        rst_n = 1'b1;
        m_state = 16'hACE1; m_taps = 15'h5008; m_attack = 1'b0;
    endtask

    // One cycle: drive at negedge, check, then advance the model at posedge.
    task automatic cyc(bit ld, logic [15:0] sd, logic [14:0] tp, bit en, bit fl, logic [2:0] cor);
        int exp;
        cfg_load = ld; cfg_seed = sd; cfg_taps = tp; step_en = en;
        chk_fail = fl; corrupt = cor;
        #1;
        exp = model_sel(m_state) ^ (fl ? 7 : 0);
        check(int'(err_word) == exp, fl ? "R7 complement word" : "R6/R2/R10 clean word",
              int'(err_word), exp);
        check(attack == m_attack, "R8/R9 attack flag", int'(attack), int'(m_attack));
        @(posedge clk);
        if ((((fl ? 7 : 0) ^ int'(cor)) & 7) != 0) m_attack = 1'b1;
        if (ld) begin
            m_taps  = int'(tp);
            m_state = (sd == 16'h0) ? 1 : int'(sd);
        end else if (en) begin
            m_state = model_step(m_state, m_taps);
        end
        @(negedge clk);
    endtask

    initial begin
        #(64'd8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state then R2 stepping with reset taps, link clean (R10).
        for (int i = 0; i < 40; i++) cyc(0, '0, '0, 1, 0, 3'b000);
        // R5 hold with step disabled.
        for (int i = 0; i < 6; i++) cyc(0, '0, '0, 0, 0, 3'b000);
        // R3 load new seed and taps, then step with them.
        cyc(1, 16'h1234, 15'h2A51, 0, 0, 3'b000);
        for (int i = 0; i < 60; i++) cyc(0, '0, '0, 1, 0, 3'b000);
        // R3 load takes priority over a step in the same cycle.
        cyc(1, 16'h8001, 15'h7FFF, 1, 0, 3'b000);
        for (int i = 0; i < 40; i++) cyc(0, '0, '0, 1, 0, 3'b000);
        // R4 zero seed forced to 1.
        cyc(1, 16'h0000, 15'h0B00, 1, 0, 3'b000);
        for (int i = 0; i < 40; i++) cyc(0, '0, '0, 1, 0, 3'b000);
        // R7 checker failure flags attack; R9 flag stays set.
        cyc(0, '0, '0, 1, 1, 3'b000);
        for (int i = 0; i < 12; i++) cyc(0, '0, '0, 1, 0, 3'b000);
        // R1 reset clears, then R8 single-bit link corruption.
        do_reset();
        for (int i = 0; i < 5; i++) cyc(0, '0, '0, 1, 0, 3'b000);
        cyc(0, '0, '0, 1, 0, 3'b100);
        for (int i = 0; i < 8; i++) cyc(0, '0, '0, 0, 0, 3'b000);
        // R8 failure whose complement is undone on the link is seen as clean.
        do_reset();
        for (int i = 0; i < 4; i++) cyc(0, '0, '0, 1, 1, 3'b111);
        for (int i = 0; i < 6; i++) cyc(0, '0, '0, 1, 0, 3'b000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule